// File: doc/BRIEF.md
# RMII Transmit Serializer

This block converts an outgoing Ethernet frame, presented one byte at a time on a valid/ready stream, into the 2-bit transmit data bus and transmit-enable line of a reduced media-independent interface. It runs from the 50 MHz interface reference clock. Before the payload it inserts a run of preamble bytes and a start-of-frame delimiter. When frame check generation is enabled, it appends a CRC-32 after the last payload byte.

There are two line rates. At 100 Mbps a new dibit goes out on every clock. At 10 Mbps each dibit is held for ten clocks. The frame source only gets a ready pulse at the moment a payload byte is needed. A started frame cannot be stalled. If the source has no byte when one is requested, the frame is cut off at that byte boundary and a sticky error flag records the underrun.

Top module: `rmii_tx_serializer`

## Requirements
- R1: After reset and between frames, tx_en is 0, txd is 2'b00 and underrun is 0 until an underrun occurs.
- R2: A frame begins on the clock after in_valid is seen high while idle. tx_en then rises, and seven 0x55 bytes followed by one 0xD5 byte are sent before any payload.
- R3: Every byte goes out as four dibits, bits [1:0] first and bits [7:6] last.
- R4: With slow_mode low at frame start, a new dibit appears on every clock.
- R5: With slow_mode high at frame start, every dibit is held on txd for exactly ten clocks.
- R6: With fcs_en high at frame start, four CRC bytes follow the last payload byte. The CRC is reflected CRC-32 (polynomial 0xEDB88320), starts from all ones and is inverted at the end. It covers the payload only and is sent least significant byte first.
- R7: With fcs_en low at frame start, tx_en falls right after the last dibit of the byte flagged by in_last.
- R8: in_ready is high only on the final clock of the delimiter or of a non-final payload byte. A byte is taken when in_valid and in_ready are both high.
- R9: If in_ready is high while in_valid is low, tx_en falls on the next clock, the frame ends, and underrun becomes 1. It stays 1 through idle time and later frames.
- R10: A high underrun_clr clears underrun on the next clock, unless a new underrun happens in the same cycle.
- R11: txd is 2'b00 whenever tx_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz interface reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | 1 selects 10 Mbps pacing; sampled at frame start |
| fcs_en | input | 1 | 1 appends the CRC-32 trailer; sampled at frame start |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte present; also requests a frame start when idle |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Payload byte taken this cycle |
| underrun_clr | input | 1 | Clears the underrun flag |
| txd | output | 2 | Transmit dibit |
| tx_en | output | 1 | Transmit enable |
| underrun | output | 1 | Sticky underrun error flag |

## Verification
The hardest situation to reach from the ports is an underrun at each possible byte boundary. This includes the very first payload request after the delimiter, where in_valid has only announced the frame and then drops before any byte is taken. The stimulus supplies only a chosen number of payload bytes and then withholds in_valid. The cut-off then lands on a known dibit at both line rates. The sticky flag is then followed through idle time and through a later complete frame before it is cleared.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SFD,
      ST_DATA,
      ST_FCS
   } tx_state_e;

   // Reflected CRC-32 update over one byte, bit 0 first.
   function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                            input logic [7:0]  d,
                                            input logic [31:0] poly);
      logic [31:0] c;
      logic        fb;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction

endpackage

// File: rtl/rmii_tx_pace.sv
module rmii_tx_pace #(
   parameter int SLOW_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slow,
   output logic tick
);

   generate
      if (SLOW_DIV < 1) begin : g_bad
         $error("rmii_tx_pace: SLOW_DIV must be at least 1");
      end

      if (SLOW_DIV == 1) begin : g_flat
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(SLOW_DIV);
         logic [CW-1:0] cnt;

         assign tick = !slow || (cnt == CW'(SLOW_DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!run || tick) cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end

         // R5
         hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && slow && $past(run) && !$past(tick)) |-> (cnt == $past(cnt) + 1'b1));
      end
   endgenerate

endmodule

// File: rtl/rmii_tx_fcs.sv
module rmii_tx_fcs #(
   parameter logic [31:0] POLY = 32'hEDB88320
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   input  logic       upd,
   input  logic [7:0] data,
   input  logic       shift,
   output logic [7:0] fcs_byte
);
   import rmii_tx_pkg::*;

   logic [31:0] crc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= '1;
      else if (init)  crc <= '1;
      else if (upd)   crc <= crc_step(crc, data, POLY);
      else if (shift) crc <= {8'h00, crc[31:8]};
   end

   assign fcs_byte = ~crc[7:0];

   // R6
   fcs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd && shift));

endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
   parameter int          PRE_LEN  = 7,
   parameter logic [7:0]  PRE_BYTE = 8'h55,
   parameter logic [7:0]  SFD_BYTE = 8'hD5,
   parameter int          SLOW_DIV = 10,
   parameter int          FCS_LEN  = 4,
   parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slow_mode,
   input  logic       fcs_en,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   input  logic       in_last,
   output logic       in_ready,
   input  logic       underrun_clr,
   output logic [1:0] txd,
   output logic       tx_en,
   output logic       underrun
);
   import rmii_tx_pkg::*;

   localparam int MAXB = (PRE_LEN > FCS_LEN) ? PRE_LEN : FCS_LEN;
   localparam int CW   = $clog2(MAXB + 1);

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("rmii_tx_serializer: PRE_LEN must be at least 1");
      end
      if (FCS_LEN < 1 || FCS_LEN > 4) begin : g_bad_fcs
         $error("rmii_tx_serializer: FCS_LEN must be 1 to 4");
      end
   endgenerate

   tx_state_e     state;
   logic [7:0]    shreg;
   logic [1:0]    dib_idx;
   logic [CW-1:0] byte_cnt;
   logic          speed_q;
   logic          crc_q;
   logic          last_q;
   logic          tick;
   logic          byte_end;
   logic          need_byte;
   logic          take;
   logic          err_set;
   logic          fcs_init;
   logic          fcs_shift;
   logic [7:0]    fcs_byte;

   assign tx_en     = (state != ST_IDLE);
   assign txd       = shreg[1:0];
   assign byte_end  = tx_en && tick && (dib_idx == 2'd3);
   assign need_byte = byte_end &&
                      ((state == ST_SFD) || (state == ST_DATA && !last_q));
   assign in_ready  = need_byte;
   assign take      = need_byte && in_valid;
   assign err_set   = need_byte && !in_valid;
   assign fcs_init  = (state == ST_IDLE) && in_valid;
   assign fcs_shift = byte_end &&
                      ((state == ST_DATA && last_q && crc_q) ||
                       (state == ST_FCS && byte_cnt != CW'(FCS_LEN - 1)));

   rmii_tx_pace #(.SLOW_DIV(SLOW_DIV)) u_pace (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tx_en),
      .slow  (speed_q),
      .tick  (tick)
   );

   rmii_tx_fcs #(.POLY(CRC_POLY)) u_fcs (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (fcs_init),
      .upd      (take),
      .data     (in_data),
      .shift    (fcs_shift),
      .fcs_byte (fcs_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         dib_idx  <= '0;
         byte_cnt <= '0;
         speed_q  <= 1'b0;
         crc_q    <= 1'b0;
         last_q   <= 1'b0;
      end else if (state == ST_IDLE) begin
         if (in_valid) begin
            state    <= ST_PRE;
            shreg    <= PRE_BYTE;
            dib_idx  <= '0;
            byte_cnt <= '0;
            speed_q  <= slow_mode;
            crc_q    <= fcs_en;
            last_q   <= 1'b0;
         end
      end else if (tick) begin
         if (dib_idx != 2'd3) begin
            shreg   <= {2'b00, shreg[7:2]};
            dib_idx <= dib_idx + 2'd1;
         end else begin
            dib_idx <= '0;
            unique case (state)
               ST_PRE: begin
                  if (byte_cnt == CW'(PRE_LEN - 1)) begin
                     state <= ST_SFD;
                     shreg <= SFD_BYTE;
                  end else begin
                     byte_cnt <= byte_cnt + 1'b1;
                     shreg    <= PRE_BYTE;
                  end
               end
               ST_SFD, ST_DATA: begin
                  if (state == ST_DATA && last_q) begin
                     if (crc_q) begin
                        state    <= ST_FCS;
                        byte_cnt <= '0;
                        shreg    <= fcs_byte;
                     end else begin
                        state <= ST_IDLE;
                        shreg <= '0;
                     end
                  end else if (in_valid) begin
                     state  <= ST_DATA;
                     shreg  <= in_data;
                     last_q <= in_last;
                  end else begin
                     state <= ST_IDLE;
                     shreg <= '0;
                  end
               end
               ST_FCS: begin
                  if (byte_cnt == CW'(FCS_LEN - 1)) begin
                     state <= ST_IDLE;
                     shreg <= '0;
                  end else begin
                     byte_cnt <= byte_cnt + 1'b1;
                     shreg    <= fcs_byte;
                  end
               end
               default: begin
                  state <= ST_IDLE;
                  shreg <= '0;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            underrun <= 1'b0;
      else if (err_set)      underrun <= 1'b1;
      else if (underrun_clr) underrun <= 1'b0;
   end

   // R11
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> (txd == 2'b00));

   // R8
   ready_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (state == ST_SFD || state == ST_DATA));

   // R9
   underrun_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> (!tx_en && underrun));

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !underrun_clr) |=> underrun);

   // R10
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun_clr && !(in_ready && !in_valid)) |=> !underrun);

   // R5
   slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && speed_q && !tick) |=> $stable(txd));

   // R4
   fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !speed_q && dib_idx != 2'd3) |=> (dib_idx == 2'($past(dib_idx) + 2'd1)));

endmodule

// File: tb/rmii_tx_serializer_bench.sv
module rmii_tx_serializer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slow_mode = 1'b0;
   logic       fcs_en = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic       underrun_clr = 1'b0;
   logic [1:0] txd;
   logic       tx_en;
   logic       underrun;

   always #4 clk = ~clk;

   rmii_tx_serializer u_rmii_tx_serializer (
      .clk          (clk),
      .rst_n        (rst_n),
      .slow_mode    (slow_mode),
      .fcs_en       (fcs_en),
      .in_data      (in_data),
      .in_valid     (in_valid),
      .in_last      (in_last),
      .in_ready     (in_ready),
      .underrun_clr (underrun_clr),
      .txd          (txd),
      .tx_en        (tx_en),
      .underrun     (underrun)
   );

   int         vectors = 0;
   int         fails = 0;
   bit         done = 1'b0;
   logic [1:0] expq[$];
   string      tagq[$];
   logic [7:0] payload[$];
   bit         trunc_pending = 1'b0;
   bit         exp_err = 1'b0;
   bit         clr_req = 1'b0;
   bit         clr_pending = 1'b0;
   bit         took = 1'b0;
   bit         active = 1'b0;
   int         idx = 0;
   int         nsupply = 0;
   string      idle_tag = "R1";

   function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
      logic [31:0] r = 32'hFFFF_FFFF;
      foreach (b[k]) begin
         r = r ^ {24'h0, b[k]};
         for (int j = 0; j < 8; j++)
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      end
      return ~r;
   endfunction

   task automatic push_byte(input logic [7:0] b, input int hold, input string tag);
      for (int i = 0; i < 4; i++)
         for (int h = 0; h < hold; h++) begin
            expq.push_back(b[2*i +: 2]);
            tagq.push_back(tag);
         end
   endtask

   task automatic compare();
      logic [1:0] e;
      string      t;
      vectors++;
      if (clr_pending) begin
         exp_err     = 1'b0;
         clr_pending = 1'b0;
      end
      if (expq.size() > 0) begin
         e = expq.pop_front();
         t = tagq.pop_front();
         if (tx_en !== 1'b1 || txd !== e) begin
            fails++;
            $display("FAIL %s: tx_en=%0b txd=%0d, expected tx_en=1 txd=%0d", t, tx_en, txd, e);
         end
      end else begin
         t = idle_tag;
         if (trunc_pending) begin
            exp_err       = 1'b1;
            trunc_pending = 1'b0;
            t             = "R9";
         end
         // R11: idle bus is quiet
         if (tx_en !== 1'b0 || txd !== 2'b00) begin
            fails++;
            $display("FAIL %s: tx_en=%0b txd=%0d, expected tx_en=0 txd=0", t, tx_en, txd);
         end
         // R8: no request while idle
         if (in_ready !== 1'b0) begin
            fails++;
            $display("FAIL R8: in_ready=%0b while idle, expected 0", in_ready);
         end
      end
      if (underrun !== exp_err) begin
         fails++;
         $display("FAIL %s: underrun=%0b, expected %0b", (t == "R9") ? "R9" : "R10", underrun, exp_err);
      end
   endtask

   task automatic drive();
      if (took) idx++;
      if (active && idx < nsupply && idx < payload.size()) begin
         in_valid = 1'b1;
         in_data  = payload[idx];
         in_last  = (idx == payload.size() - 1);
      end else begin
         active   = 1'b0;
         in_valid = 1'b0;
         in_last  = 1'b0;
      end
      underrun_clr = clr_req;
      if (clr_req) clr_pending = 1'b1;
      clr_req = 1'b0;
      took = in_valid && in_ready;
   endtask

   task automatic cycle();
      @(negedge clk);
      compare();
      drive();
   endtask

   task automatic run_frame(input bit use_crc, input bit slow, input int nsup);
      int          hold;
      int          nsent;
      logic [31:0] c;
      @(negedge clk);
      compare();
      hold  = slow ? 10 : 1;
      nsent = (nsup < payload.size()) ? nsup : payload.size();
      // R2: preamble and delimiter first
      for (int p = 0; p < 7; p++) push_byte(8'h55, hold, "R2");
      push_byte(8'hD5, hold, "R2");
      // R3 / R4 / R5: payload dibits
      for (int p = 0; p < nsent; p++) push_byte(payload[p], hold, slow ? "R5" : "R3");
      if (nsup >= payload.size() && use_crc) begin
         c = ref_crc(payload);
         // R6: trailer, least significant byte first
         for (int p = 0; p < 4; p++) push_byte(c[8*p +: 8], hold, "R6");
      end
      trunc_pending = (nsup < payload.size());
      idle_tag      = trunc_pending ? "R1" : (use_crc ? "R6" : "R7");
      fcs_en        = use_crc;
      slow_mode     = slow;
      in_valid      = 1'b1;
      in_data       = payload[0];
      in_last       = (payload.size() == 1);
      underrun_clr  = 1'b0;
      idx           = 0;
      nsupply       = nsup;
      active        = 1'b1;
      took          = 1'b0;
      while (expq.size() > 0 || trunc_pending) cycle();
      repeat (6) cycle();
   endtask

   initial begin
      logic [31:0] kv;
      // R1: reset state
      @(negedge clk);
      vectors++;
      if (tx_en !== 1'b0 || underrun !== 1'b0 || txd !== 2'b00) begin
         fails++;
         $display("FAIL R1: tx_en=%0b txd=%0d underrun=%0b, expected 0 0 0", tx_en, txd, underrun);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) cycle();

      // R6: bench CRC against the well-known check value
      payload = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      kv = ref_crc(payload);
      vectors++;
      if (kv !== 32'hCBF43926) begin
         fails++;
         $display("FAIL R6: reference crc=%h, expected cbf43926", kv);
      end

      // R3 R7: fast, no trailer
      payload = '{8'h11, 8'h22, 8'hA5};
      run_frame(1'b0, 1'b0, 3);

      // R4 R6: fast, trailer over the check string
      payload = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      run_frame(1'b1, 1'b0, 9);

      // R5 R6: slow, trailer
      payload = '{8'h3C, 8'hC3};
      run_frame(1'b1, 1'b1, 2);

      // R5 R7: slow single byte, no trailer
      payload = '{8'h9B};
      run_frame(1'b0, 1'b1, 1);

      // R9: fast, source starves after two bytes
      payload = '{8'h0F, 8'hF0, 8'h81, 8'h7E};
      run_frame(1'b0, 1'b0, 2);
      repeat (20) cycle();
      // R10: clear the flag
      clr_req = 1'b1;
      repeat (5) cycle();

      // R9: slow, no byte ever supplied after the start request
      payload = '{8'h99};
      run_frame(1'b1, 1'b1, 0);
      // R9: flag survives a complete frame
      payload = '{8'hE7};
      run_frame(1'b1, 1'b0, 1);
      // R10
      clr_req = 1'b1;
      repeat (5) cycle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule